// File: doc/BRIEF.md
# Configurable UART Frame Receiver

This block pulls characters off an asynchronous serial line. The line idles high, and a tick strobe that fires sixteen times per bit period paces the sampling. The shape of each frame comes from a small set of line-control inputs: a word-length code for 5 to 8 data bits, a parity-enable, an even/odd select and a stick-parity select. These are the same settings a matching transmitter would use.

Each completed character is presented right-aligned on a data bus together with a one-cycle valid strobe. Three flags are presented alongside it: a parity error, a framing error and a break indication. The flags and the data hold their values until the next character completes.

The block has no FIFO, no interrupt logic, no baud divisor and no register interface. The caller supplies the tick and the configuration and consumes the valid strobe. The serial input must already be synchronous to `clk`.

Top module: `uart_frame_rx`

## Requirements
- R1: While `rst_n` is low, and after it rises until the first character completes, `rx_valid`, `rx_perr`, `rx_ferr`, `rx_brk` and `rx_data` are all 0. After reset the receiver accepts no start bit until the line has been seen high on a tick.
- R2: The word-length code selects the number of data bits: 2'b00 selects 5, 2'b01 selects 6, 2'b10 selects 7 and 2'b11 selects 8. Data bits arrive least significant first. `rx_data[n-1:0]` holds them and the bits above them read 0.
- R3: A start is detected when the idle line reads low on a tick. The line is sampled again on the 8th tick after that detection. If it is high there, the frame is dropped, no character is produced, and the receiver returns to waiting for a start.
- R4: After the confirmed start sample, every later bit is sampled on each 16th tick. `rx_valid` goes high for exactly one clock, in the clock cycle after the tick that samples the stop bit. Data and flags update on that same edge.
- R5: With parity enabled, the bit after the last data bit is the parity bit. If even parity is selected and the data bits plus the parity bit hold an odd count of ones, `rx_perr` is set. If odd parity is selected and they hold an even count, `rx_perr` is set.
- R6: With parity and stick parity both enabled, the parity bit must read 1 when odd is selected and 0 when even is selected. Any other value sets `rx_perr`, whatever the data.
- R7: With parity disabled, no parity bit is expected and `rx_perr` is 0. The even/odd and stick selections have no effect.
- R8: Only the first stop bit is sampled. A 0 there sets `rx_ferr`. A new start bit that directly follows a single stop bit is accepted.
- R9: `rx_brk` is set when every data bit, the parity bit (if one is present) and the stop bit all read 0.
- R10: After a character completes, a new start is accepted only once the line has read high on a tick. A line held low after a break produces no further characters.
- R11: The four configuration inputs are captured when the start is detected. Changing them during a frame does not affect that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| baud_tick | input | 1 | One-cycle strobe at 16 times the bit rate |
| rxd | input | 1 | Serial line, idle high, synchronous to clk |
| cfg_wlen | input | 2 | Word-length code (00 to 11 select 5 to 8 bits) |
| cfg_par_en | input | 1 | Parity bit present and checked |
| cfg_par_even | input | 1 | 1 selects even parity, 0 selects odd |
| cfg_par_stick | input | 1 | Parity bit is a fixed value |
| rx_data | output | 8 | Received character, right-aligned |
| rx_valid | output | 1 | One-cycle strobe for a completed character |
| rx_perr | output | 1 | Parity error for the presented character |
| rx_ferr | output | 1 | Framing error (first stop bit was 0) |
| rx_brk | output | 1 | Break: the whole frame read 0 |

## Verification
The bench targets the following corner cases:

- **Frame length.** It changes the frame length through every word-length code, with and without parity. A receiver that counted one bit too few or too many would shift the character, or would read the parity bit as the stop bit.
- **Parity.** Stick parity is driven with both correct and wrong values, and with data whose ones count would pass the plain even/odd check. A receiver that ignored the stick selection, or let it leak through while parity is disabled, would raise the wrong flag.
- **Start and re-arm.** Short low glitches test false-start rejection. A line held low after a break tests the wait-for-high rule; a receiver lacking it would emit a stream of phantom break characters.
- **Timing and configuration.** Back-to-back frames and tick rates of one tick per clock and one per three clocks test the sampling timing. Configuration changes in mid-frame show whether the settings are captured at the start.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

  localparam int RX_DATA_W   = 8;
  localparam int RX_MIN_BITS = 5;
  localparam int RX_IDX_W    = $clog2(RX_DATA_W);

  typedef enum logic [2:0] {
    RX_WAIT_HIGH,
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_PARITY,
    RX_STOP
  } rx_state_e;

  typedef struct packed {
    logic [1:0] wlen;
    logic       par_en;
    logic       par_even;
    logic       par_stick;
  } rx_cfg_t;

  // number of data bits selected by the word-length code
  function automatic int unsigned word_bits(input logic [1:0] wlen);
    return RX_MIN_BITS + int'(wlen);
  endfunction

  // parity verdict for a completed character (data upper bits are zero)
  function automatic logic parity_bad(input logic [RX_DATA_W-1:0] d,
                                      input logic pbit,
                                      input rx_cfg_t c);
    if (!c.par_en)   return 1'b0;
    if (c.par_stick) return pbit != !c.par_even;
    return (^{d, pbit}) == c.par_even;
  endfunction

endpackage

// File: rtl/uart_rx_bitclk.sv
module uart_rx_bitclk #(
  parameter int OVERSAMPLE = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic clr,
  output logic half_hit,
  output logic full_hit
);
  localparam int CW   = $clog2(OVERSAMPLE);
  localparam int HALF = OVERSAMPLE / 2;

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)    cnt <= '0;
    else if (clr)  cnt <= '0;
    else if (tick) cnt <= (cnt == CW'(OVERSAMPLE - 1)) ? '0 : cnt + 1'b1;
  end

  assign half_hit = tick && (cnt == CW'(HALF - 1));
  assign full_hit = tick && (cnt == CW'(OVERSAMPLE - 1));

  // R4
  wrap_to_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    full_hit |=> cnt == '0)
    else $error("tick counter did not wrap after a full bit");

endmodule

// File: rtl/uart_rx_fsm.sv
module uart_rx_fsm
  import uart_rx_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick,
  input  logic                rxd,
  input  rx_cfg_t             cfg_in,
  input  logic                half_hit,
  input  logic                full_hit,
  output logic                cnt_clr,
  output logic                start_ok,
  output logic                take_data,
  output logic                take_par,
  output logic                take_stop,
  output logic [RX_IDX_W-1:0] bit_idx,
  output rx_cfg_t             cfg_q
);
  rx_state_e state, state_nx;
  logic start_seen, start_false, last_data;
  logic [RX_IDX_W-1:0] last_idx;

  assign last_idx    = RX_IDX_W'(word_bits(cfg_q.wlen) - 1);
  assign start_seen  = (state == RX_IDLE)   && tick && !rxd;
  assign start_false = (state == RX_START)  && half_hit && rxd;
  assign start_ok    = (state == RX_START)  && half_hit && !rxd;
  assign take_data   = (state == RX_DATA)   && full_hit;
  assign take_par    = (state == RX_PARITY) && full_hit;
  assign take_stop   = (state == RX_STOP)   && full_hit;
  assign last_data   = take_data && (bit_idx == last_idx);
  assign cnt_clr     = start_seen || start_ok;

  always_comb begin
    state_nx = state;
    case (state)
      RX_WAIT_HIGH: if (tick && rxd) state_nx = RX_IDLE;
      RX_IDLE:      if (start_seen)  state_nx = RX_START;
      RX_START: begin
        if (start_false)   state_nx = RX_IDLE;
        else if (start_ok) state_nx = RX_DATA;
      end
      RX_DATA:      if (last_data) state_nx = cfg_q.par_en ? RX_PARITY : RX_STOP;
      RX_PARITY:    if (take_par)  state_nx = RX_STOP;
      RX_STOP:      if (take_stop) state_nx = RX_WAIT_HIGH;
      default:      state_nx = RX_WAIT_HIGH;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= RX_WAIT_HIGH;
      bit_idx <= '0;
      cfg_q   <= '0;
    end else begin
      state <= state_nx;
      if (start_seen) cfg_q <= cfg_in;
      if (start_ok)       bit_idx <= '0;
      else if (take_data) bit_idx <= bit_idx + 1'b1;
    end
  end

  // R3
  false_start_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_false |=> state == RX_IDLE)
    else $error("false start not dropped");

  // R2
  bit_index_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state == RX_DATA |-> int'(bit_idx) < int'(word_bits(cfg_q.wlen)))
    else $error("bit index beyond word length");

  // R10
  rearm_after_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_stop |=> state == RX_WAIT_HIGH)
    else $error("receiver did not wait for idle line");

  // R11
  cfg_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == RX_DATA || state == RX_PARITY || state == RX_STOP) |=> $stable(cfg_q))
    else $error("configuration moved inside a frame");

endmodule

// File: rtl/uart_rx_collect.sv
module uart_rx_collect
  import uart_rx_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 rxd,
  input  rx_cfg_t              cfg_q,
  input  logic                 start_ok,
  input  logic                 take_data,
  input  logic                 take_par,
  input  logic                 take_stop,
  input  logic [RX_IDX_W-1:0]  bit_idx,
  output logic [RX_DATA_W-1:0] rx_data,
  output logic                 rx_valid,
  output logic                 rx_perr,
  output logic                 rx_ferr,
  output logic                 rx_brk
);
  logic [RX_DATA_W-1:0] acc;
  logic                 par_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc      <= '0;
      par_q    <= 1'b0;
      rx_data  <= '0;
      rx_valid <= 1'b0;
      rx_perr  <= 1'b0;
      rx_ferr  <= 1'b0;
      rx_brk   <= 1'b0;
    end else begin
      rx_valid <= take_stop;
      if (start_ok) begin
        acc   <= '0;
        par_q <= 1'b0;
      end
      if (take_data) acc[bit_idx] <= rxd;
      if (take_par)  par_q <= rxd;
      if (take_stop) begin
        rx_data <= acc;
        rx_perr <= parity_bad(acc, par_q, cfg_q);
        rx_ferr <= !rxd;
        rx_brk  <= (acc == '0) && !par_q && !rxd;
      end
    end
  end

  // R4
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid)
    else $error("valid held longer than one cycle");

  // R9
  break_has_ferr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && rx_brk |-> rx_ferr)
    else $error("break without framing error");

  // R2
  upper_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> (rx_data >> word_bits(cfg_q.wlen)) == '0)
    else $error("bits above word length not zero");

  // R7
  no_parity_no_perr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && !cfg_q.par_en |-> !rx_perr)
    else $error("parity error with parity disabled");

endmodule

// File: rtl/uart_frame_rx.sv
module uart_frame_rx
  import uart_rx_pkg::*;
#(
  parameter int OVERSAMPLE = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 baud_tick,
  input  logic                 rxd,
  input  logic [1:0]           cfg_wlen,
  input  logic                 cfg_par_en,
  input  logic                 cfg_par_even,
  input  logic                 cfg_par_stick,
  output logic [RX_DATA_W-1:0] rx_data,
  output logic                 rx_valid,
  output logic                 rx_perr,
  output logic                 rx_ferr,
  output logic                 rx_brk
);
  rx_cfg_t             cfg_in, cfg_q;
  logic                half_hit, full_hit, cnt_clr;
  logic                start_ok, take_data, take_par, take_stop;
  logic [RX_IDX_W-1:0] bit_idx;

  assign cfg_in = '{wlen: cfg_wlen, par_en: cfg_par_en,
                    par_even: cfg_par_even, par_stick: cfg_par_stick};

  uart_rx_bitclk #(.OVERSAMPLE(OVERSAMPLE)) u_bitclk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (baud_tick),
    .clr      (cnt_clr),
    .half_hit (half_hit),
    .full_hit (full_hit)
  );

  uart_rx_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (baud_tick),
    .rxd       (rxd),
    .cfg_in    (cfg_in),
    .half_hit  (half_hit),
    .full_hit  (full_hit),
    .cnt_clr   (cnt_clr),
    .start_ok  (start_ok),
    .take_data (take_data),
    .take_par  (take_par),
    .take_stop (take_stop),
    .bit_idx   (bit_idx),
    .cfg_q     (cfg_q)
  );

  uart_rx_collect u_collect (
    .clk       (clk),
    .rst_n     (rst_n),
    .rxd       (rxd),
    .cfg_q     (cfg_q),
    .start_ok  (start_ok),
    .take_data (take_data),
    .take_par  (take_par),
    .take_stop (take_stop),
    .bit_idx   (bit_idx),
    .rx_data   (rx_data),
    .rx_valid  (rx_valid),
    .rx_perr   (rx_perr),
    .rx_ferr   (rx_ferr),
    .rx_brk    (rx_brk)
  );

endmodule

// File: tb/sim_uart_frame_rx.sv
`timescale 1ns/1ps
module sim_uart_frame_rx;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       baud_tick = 1'b0;
  logic       rxd = 1'b1;
  logic [1:0] cfg_wlen = 2'd0;
  logic       cfg_par_en = 1'b0, cfg_par_even = 1'b0, cfg_par_stick = 1'b0;
  logic [7:0] rx_data;
  logic       rx_valid, rx_perr, rx_ferr, rx_brk;

  int checks = 0, errors = 0;
  int tdiv = 2, tdiv_cnt = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  uart_frame_rx u0 (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .rxd(rxd),
    .cfg_wlen(cfg_wlen), .cfg_par_en(cfg_par_en), .cfg_par_even(cfg_par_even),
    .cfg_par_stick(cfg_par_stick), .rx_data(rx_data), .rx_valid(rx_valid),
    .rx_perr(rx_perr), .rx_ferr(rx_ferr), .rx_brk(rx_brk));

  function automatic bit want_perr(input logic [7:0] d, input bit pb,
                                   input bit en, input bit ev, input bit st);
    if (!en) return 0;
    if (st)  return pb != !ev;
    return (((($countones(d) + int'(pb)) % 2) == 1) == ev);
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // tick generator
  always @(negedge clk) begin
    if (!rst_n) begin
      tdiv_cnt = 0;
      baud_tick <= 1'b0;
    end else begin
      baud_tick <= (tdiv_cnt == 0);
      tdiv_cnt = (tdiv_cnt + 1 >= tdiv) ? 0 : tdiv_cnt + 1;
    end
  end

  // behavioural reference: time since start measured in ticks
  int         m_mode, m_t, m_k, m_nb;
  logic [7:0] m_dat;
  bit         m_pb, m_pen, m_pev, m_pst;
  logic [7:0] e_data;
  bit         e_valid, e_perr, e_ferr, e_brk;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mode = 0; m_t = 0; e_data = 0;
      e_valid = 0; e_perr = 0; e_ferr = 0; e_brk = 0;
    end else begin
      e_valid = 0;
      if (baud_tick) begin
        if (m_mode == 0) begin
          if (rxd) m_mode = 1;
        end else if (m_mode == 1) begin
          if (!rxd) begin
            m_mode = 2; m_t = 0; m_dat = 0; m_pb = 0;
            m_nb = 5 + int'(cfg_wlen); m_pen = cfg_par_en;
            m_pev = cfg_par_even; m_pst = cfg_par_stick;
          end
        end else begin
          m_t++;
          if (m_t == 8) begin
            if (rxd) m_mode = 1;
          end else if (m_t > 8 && (m_t - 8) % 16 == 0) begin
            m_k = (m_t - 8) / 16;
            if (m_k <= m_nb) m_dat[m_k-1] = rxd;
            else if (m_pen && m_k == m_nb + 1) m_pb = rxd;
            else begin
              e_valid = 1; e_data = m_dat;
              e_perr = want_perr(m_dat, m_pb, m_pen, m_pev, m_pst);
              e_ferr = !rxd;
              e_brk  = (m_dat == 0) && !m_pb && !rxd;
              m_mode = 0;
            end
          end
        end
      end
    end
  end

  // per-clock comparison and character capture
  int         got_n = 0;
  logic [7:0] got_d;
  bit         got_p, got_f, got_b;

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk({rx_valid, rx_data, rx_perr, rx_ferr, rx_brk} ==
          {e_valid, e_data, e_perr, e_ferr, e_brk}, "R4 per-clock model",
          {rx_valid, rx_data, rx_perr, rx_ferr, rx_brk},
          {e_valid, e_data, e_perr, e_ferr, e_brk});
      if (rx_valid) begin
        got_n++; got_d = rx_data; got_p = rx_perr; got_f = rx_ferr; got_b = rx_brk;
      end
    end
  end

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_cfg(input int w, input bit en, input bit ev, input bit st);
    cfg_wlen = 2'(w); cfg_par_en = en; cfg_par_even = ev; cfg_par_stick = st;
  endtask

  task automatic send_frame(input logic [7:0] d, input int nb, input bit hp,
                            input bit pb, input bit sv, input int gap_bits);
    int bc;
    bc = 16 * tdiv;
    rxd = 1'b0; wait_clk(bc);
    for (int i = 0; i < nb; i++) begin rxd = d[i]; wait_clk(bc); end
    if (hp) begin rxd = pb; wait_clk(bc); end
    rxd = sv; wait_clk(bc);
    rxd = 1'b1; wait_clk(gap_bits * bc);
  endtask

  task automatic expect_frame(input int n0, input logic [7:0] d, input bit p,
                              input bit f, input bit b, input string tag);
    chk(got_n == n0 + 1, {tag, " count"}, got_n, n0 + 1);
    chk(got_d == d, {tag, " data"}, got_d, d);
    chk(got_p == p, {tag, " perr"}, got_p, p);
    chk(got_f == f, {tag, " ferr"}, got_f, f);
    chk(got_b == b, {tag, " brk"}, got_b, b);
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      finished = 1;
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int n0;
    logic [7:0] d;
    bit pb;
    wait_clk(5);
    // R1 reset values
    chk({rx_valid, rx_data, rx_perr, rx_ferr, rx_brk} == 0, "R1 reset outputs",
        {rx_valid, rx_data, rx_perr, rx_ferr, rx_brk}, 0);
    rst_n = 1'b1;
    wait_clk(40);
    chk({rx_valid, rx_data, rx_perr, rx_ferr, rx_brk} == 0, "R1 idle after reset",
        {rx_valid, rx_data, rx_perr, rx_ferr, rx_brk}, 0);

    // R2 every word length, no parity
    for (int w = 0; w < 4; w++) begin
      d = 8'hA5 & 8'((1 << (5 + w)) - 1);
      set_cfg(w, 0, 0, 0); n0 = got_n;
      send_frame(d, 5 + w, 0, 0, 1, 1);
      expect_frame(n0, d, 0, 0, 0, "R2 word length");
      d = 8'h5A & 8'((1 << (5 + w)) - 1);
      n0 = got_n;
      send_frame(d, 5 + w, 0, 0, 1, 1);
      expect_frame(n0, d, 0, 0, 0, "R2 word length alt");
    end

    // R5 even and odd parity, right and wrong bit
    for (int ev = 0; ev < 2; ev++) begin
      d = 8'h37;
      pb = ev ? ^d : ~^d;
      set_cfg(3, 1, ev[0], 0); n0 = got_n;
      send_frame(d, 8, 1, pb, 1, 1);
      expect_frame(n0, d, 0, 0, 0, "R5 parity good");
      n0 = got_n;
      send_frame(d, 8, 1, !pb, 1, 1);
      expect_frame(n0, d, 1, 0, 0, "R5 parity bad");
      d = 8'h2C;
      pb = ev ? ^d : ~^d;
      set_cfg(1, 1, ev[0], 0); n0 = got_n;
      send_frame(d, 6, 1, pb, 1, 1);
      expect_frame(n0, d, 0, 0, 0, "R5 parity six bits");
    end

    // R6 stick parity
    for (int ev = 0; ev < 2; ev++) begin
      set_cfg(2, 1, ev[0], 1);
      for (int v = 0; v < 2; v++) begin
        n0 = got_n;
        send_frame(8'h13, 7, 1, v[0], 1, 1);
        expect_frame(n0, 8'h13, want_perr(8'h13, v[0], 1, ev[0], 1), 0, 0, "R6 stick");
      end
    end

    // R7 parity disabled, other selections set
    set_cfg(3, 0, 1, 1); n0 = got_n;
    send_frame(8'h07, 8, 0, 0, 1, 1);
    expect_frame(n0, 8'h07, 0, 0, 0, "R7 parity off");
    set_cfg(0, 0, 0, 1); n0 = got_n;
    send_frame(8'h10, 5, 0, 0, 1, 1);
    expect_frame(n0, 8'h10, 0, 0, 0, "R7 stick ignored");

    // R8 framing error, then back-to-back frames on one stop bit
    set_cfg(3, 0, 0, 0); n0 = got_n;
    send_frame(8'h81, 8, 0, 0, 0, 1);
    expect_frame(n0, 8'h81, 0, 1, 0, "R8 framing");
    n0 = got_n;
    send_frame(8'hC3, 8, 0, 0, 1, 0);
    send_frame(8'h3C, 8, 0, 0, 1, 1);
    chk(got_n == n0 + 2, "R8 back-to-back count", got_n, n0 + 2);
    chk(got_d == 8'h3C, "R8 back-to-back data", got_d, 8'h3C);

    // R9 break, R10 held-low line yields nothing more
    set_cfg(3, 1, 1, 0); n0 = got_n;
    send_frame(8'h00, 8, 1, 1, 0, 1);
    expect_frame(n0, 8'h00, 1, 1, 0, "R9 parity one no break");
    n0 = got_n;
    rxd = 1'b0; wait_clk(16 * tdiv * 40);
    chk(got_n == n0 + 1, "R10 single break while low", got_n, n0 + 1);
    chk(got_b == 1 && got_f == 1, "R9 break flags", {got_b, got_f}, 2'b11);
    rxd = 1'b1; wait_clk(16 * tdiv * 2);
    n0 = got_n;
    send_frame(8'h66, 8, 1, 0, 1, 1);
    expect_frame(n0, 8'h66, 0, 0, 0, "R10 recovery");

    // R3 false starts of 3 and 7 ticks
    n0 = got_n;
    rxd = 1'b0; wait_clk(3 * tdiv); rxd = 1'b1; wait_clk(16 * tdiv * 14);
    rxd = 1'b0; wait_clk(7 * tdiv); rxd = 1'b1; wait_clk(16 * tdiv * 14);
    chk(got_n == n0, "R3 glitch rejected", got_n, n0);
    send_frame(8'h99, 8, 1, 0, 1, 1);
    expect_frame(n0, 8'h99, 0, 0, 0, "R3 after glitch");

    // R11 configuration change mid-frame
    set_cfg(3, 0, 0, 0); n0 = got_n;
    fork
      send_frame(8'hB4, 8, 0, 0, 1, 1);
      begin wait_clk(16 * tdiv * 3); set_cfg(0, 1, 1, 1); end
    join
    expect_frame(n0, 8'hB4, 0, 0, 0, "R11 cfg captured");

    // R4 other tick rates
    set_cfg(3, 0, 0, 0);
    tdiv = 1; wait_clk(40); n0 = got_n;
    send_frame(8'hE7, 8, 0, 0, 1, 1);
    expect_frame(n0, 8'hE7, 0, 0, 0, "R4 tick every clock");
    tdiv = 3; wait_clk(60); n0 = got_n;
    set_cfg(2, 1, 0, 0);
    send_frame(8'h55, 7, 1, 1, 1, 1);
    expect_frame(n0, 8'h55, want_perr(8'h55, 1, 1, 0, 0), 0, 0, "R4 tick every third");

    wait_clk(20);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule